// File: doc/BRIEF.md
# Port pin-change interrupt detector

This block watches a small general-purpose I/O port and raises a shared interrupt flag when an enabled pin differs from a reference snapshot of the port. Whenever the processor touches the port, the snapshot is re-taken. Reads and read-modify-write stores both count, because a store also samples the pins. Each pin is compared with its snapshot all the time. A per-pin enable mask decides which pins take part. Any single enabled difference sets the flag.

Time is counted in four-phase instruction cycles, with one clock per phase and the phase number supplied by the core. The snapshot is taken on the second phase of a cycle that accesses the port. The flag register is written only at the close of the fourth phase. It collects every difference seen during that cycle and any clear request made during it.

If a pin moves in the very phase the snapshot is taken, the snapshot already holds the new level, so that change can go unreported. With `FIX_RACE` = 0 the block keeps this behaviour. With `FIX_RACE` = 1 the block compares the live pins against the old snapshot in that phase, so the change still sets the flag.

Top module: `pin_change_detect`

## Requirements
- R1: After reset, flag_o is 0. At the first clock edge after rst_ni rises, the snapshot loads the current pins, so steady pins raise no flag.
- R2: A pin whose en_i bit is 0 never sets the flag, however it moves.
- R3: A difference on any single enabled pin between pins_i and its snapshot sets the flag.
- R4: phase_i encodes Q1..Q4 as 0..3. flag_o changes only at the clock edge that ends a Q4 phase (phase_i = 3), and it reflects differences seen in any phase of that cycle.
- R5: The snapshot is reloaded from pins_i at the edge that ends a phase with acc_i = 1 and phase_i = 1 (Q2). acc_i in any other phase does not reload it.
- R6: While an enabled difference persists, the flag is set again in every cycle, so a clear request has no lasting effect until the port is accessed.
- R7: clr_i held in a cycle that sees no enabled difference clears the flag at that cycle's Q4 edge.
- R8: When a cycle sees both a set condition and clr_i, the flag ends up 1.
- R9: With FIX_RACE = 0, a pin change that first appears in the Q2 phase of an accessing cycle does not set the flag.
- R10: With FIX_RACE = 1, the same change sets the flag at that cycle's Q4 edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Phase clock, one edge per phase |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | PIN_W | Synchronized port pin levels |
| en_i | input | PIN_W | Per-pin change-detect enable |
| phase_i | input | 2 | Current phase, 0..3 for Q1..Q4 |
| acc_i | input | 1 | Core is accessing the port (read or store) |
| clr_i | input | 1 | Request to clear the flag |
| flag_o | output | 1 | Registered change flag, used as interrupt request |

## Verification
The hardest case to reach is a pin edge that lands exactly on the capture phase of an accessing cycle. Whether that edge is lost depends on phase alignment, not on pin levels. The bench drives pins per phase, so it can move a pin at the start of Q2 while acc_i is high. It runs both FIX_RACE settings side by side on the same stimulus, so the lost case and the recovered case are checked in the same cycle. A sweep of every enable mask against every single-pin toggle, followed by a long pseudo-random run, covers set/clear collisions and accesses in the wrong phase.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;
endpackage

// File: rtl/ioc_ref_latch.sv
module ioc_ref_latch #(
  parameter int PIN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIN_W-1:0] pins_i,
  input  logic             cap_i,
  output logic [PIN_W-1:0] ref_o,
  output logic             live_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o  <= '0;
      live_o <= 1'b0;
    end else if (!live_o) begin
      ref_o  <= pins_i;  // first edge after reset
      live_o <= 1'b1;
    end else if (cap_i) begin
      ref_o  <= pins_i;
    end
  end

  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_o && !cap_i) |=> $stable(ref_o)); // R5
  AST_REF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_o && cap_i) |=> (ref_o == $past(pins_i))); // R5
endmodule

// File: rtl/ioc_compare.sv
module ioc_compare #(
  parameter int PIN_W    = 6,
  parameter bit FIX_RACE = 1'b0
) (
  input  logic [PIN_W-1:0] pins_i,
  input  logic [PIN_W-1:0] ref_i,
  input  logic [PIN_W-1:0] en_i,
  input  logic             cap_i,
  input  logic             live_i,
  output logic             hit_o
);
  logic [PIN_W-1:0] diff;

  for (genvar g = 0; g < PIN_W; g++) begin : g_pin
    assign diff[g] = en_i[g] & (pins_i[g] ^ ref_i[g]);
  end

  if (FIX_RACE) begin : g_fixed
    // compare against the old snapshot even while it is reloaded
    assign hit_o = live_i & (|diff);
  end else begin : g_racy
    // snapshot already reflects the live pins in the capture phase
    assign hit_o = live_i & (|diff) & ~cap_i;
  end
endmodule

// File: rtl/ioc_flag_ctrl.sv
module ioc_flag_ctrl
  import ioc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_i,
  input  logic   hit_i,
  input  logic   clr_i,
  output logic   flag_o
);
  logic seen_q, clr_q;
  logic set_any, clr_any, end_cyc;

  assign end_cyc = (phase_i == PH_Q4);
  assign set_any = seen_q | hit_i;
  assign clr_any = clr_q | clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      clr_q  <= 1'b0;
      flag_o <= 1'b0;
    end else if (end_cyc) begin
      flag_o <= set_any | (flag_o & ~clr_any);  // set wins
      seen_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      seen_q <= set_any;
      clr_q  <= clr_any;
    end
  end

  AST_FLAG_Q4_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_Q4) |=> $stable(flag_o)); // R4
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_cyc && set_any) |=> flag_o); // R8
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_cyc && clr_any && !set_any) |=> !flag_o); // R7
endmodule

// File: rtl/pin_change_detect.sv
module pin_change_detect
  import ioc_pkg::*;
#(
  parameter int PIN_W    = 6,
  parameter bit FIX_RACE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIN_W-1:0] pins_i,
  input  logic [PIN_W-1:0] en_i,
  input  logic [1:0]       phase_i,
  input  logic             acc_i,
  input  logic             clr_i,
  output logic             flag_o
);
  phase_e           phase;
  logic             cap;
  logic             live;
  logic [PIN_W-1:0] ref_q;
  logic             hit;

  assign phase = phase_e'(phase_i);
  assign cap   = acc_i & (phase == PH_Q2);

  ioc_ref_latch #(.PIN_W(PIN_W)) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(pins_i),
    .cap_i (cap),
    .ref_o (ref_q),
    .live_o(live)
  );

  ioc_compare #(.PIN_W(PIN_W), .FIX_RACE(FIX_RACE)) u_cmp (
    .pins_i(pins_i),
    .ref_i (ref_q),
    .en_i  (en_i),
    .cap_i (cap),
    .live_i(live),
    .hit_o (hit)
  );

  ioc_flag_ctrl u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(phase),
    .hit_i  (hit),
    .clr_i  (clr_i),
    .flag_o (flag_o)
  );

  AST_INIT_SNAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(live) |-> (ref_q == $past(pins_i))); // R1
  AST_NO_SET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!live) |=> !flag_o); // R1
endmodule

// File: tb/pin_change_detect_bench.sv
module pin_change_detect_bench;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] pins_i = 6'h15;
  logic [W-1:0] en_i = '0;
  logic [1:0]   phase_i = 2'd0;
  logic         acc_i = 1'b0;
  logic         clr_i = 1'b0;
  logic         flag0, flag1;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [W-1:0] ref_m;
  logic [1:0]   fm;

  always #2 clk = ~clk;

  pin_change_detect #(.PIN_W(W), .FIX_RACE(1'b0)) u_pin_change_detect (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins_i), .en_i(en_i),
    .phase_i(phase_i), .acc_i(acc_i), .clr_i(clr_i), .flag_o(flag0));

  pin_change_detect #(.PIN_W(W), .FIX_RACE(1'b1)) u_pin_change_detect_fix (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins_i), .en_i(en_i),
    .phase_i(phase_i), .acc_i(acc_i), .clr_i(clr_i), .flag_o(flag1));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIL%s %s: flag=%b expected %b at %0t", "", req, act, exp, $time);
    end
  endtask

  // one instruction cycle: pa in Q1, pb in Q2..Q4; accp has one bit per phase
  task automatic cyc(input logic [W-1:0] pa, input logic [W-1:0] pb,
                     input logic [W-1:0] em, input logic [3:0] accp,
                     input logic clr, input string req);
    logic [1:0] seen;
    logic [W-1:0] pv;
    logic mm;
    seen = '0;
    for (int ph = 0; ph < 4; ph++) begin
      pv = (ph == 0) ? pa : pb;
      pins_i = pv; en_i = em; acc_i = accp[ph]; clr_i = clr; phase_i = 2'(ph);
      mm = |((pv ^ ref_m) & em);
      if (accp[ph] && ph == 1) begin
        seen[1] = seen[1] | mm;
        ref_m = pv;
      end else begin
        seen = seen | {mm, mm};
      end
      @(posedge clk);
      @(negedge clk);
      if (ph < 3) begin
        chk("R4", flag0, fm[0]);
        chk("R4", flag1, fm[1]);
      end
    end
    for (int i = 0; i < 2; i++) fm[i] = seen[i] | (fm[i] & ~clr);
    acc_i = 1'b0; clr_i = 1'b0;
    chk(req, flag0, fm[0]);
    chk(req, flag1, fm[1]);
  endtask

  // resync snapshot to p and clear both flags
  task automatic settle(input logic [W-1:0] p, input logic [W-1:0] em);
    cyc(p, p, em, 4'b0010, 1'b0, "R5");
    cyc(p, p, em, 4'b0000, 1'b1, "R7");
  endtask

  initial begin
    ref_m = 6'h15;
    fm    = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk("R1", flag0, 1'b0);
    chk("R1", flag1, 1'b0);
    en_i = '1;
    cyc(6'h15, 6'h15, '1, 4'b0000, 1'b0, "R1");
    chk("R1", flag0, 1'b0);

    // R2: disabled pins never set
    cyc(6'h2a, 6'h0f, 6'h00, 4'b0000, 1'b0, "R2");
    chk("R2", flag0, 1'b0);
    cyc(6'h14, 6'h14, 6'h3e, 4'b0000, 1'b0, "R2");
    chk("R2", flag1, 1'b0);

    // R3 / R6: single enabled mismatch sets, persists across clear
    cyc(6'h17, 6'h17, '1, 4'b0000, 1'b0, "R3");
    chk("R3", flag0, 1'b1);
    cyc(6'h17, 6'h17, '1, 4'b0000, 1'b1, "R6");
    chk("R6", flag0, 1'b1);

    // R5: access outside Q2 does not reload
    cyc(6'h17, 6'h17, '1, 4'b1101, 1'b1, "R5");
    chk("R5", flag0, 1'b1);
    // store-type access in Q2 reloads; set wins in that cycle (R8)
    cyc(6'h17, 6'h17, '1, 4'b0010, 1'b1, "R8");
    chk("R8", flag0, 1'b1);
    cyc(6'h17, 6'h17, '1, 4'b0000, 1'b1, "R7");
    chk("R7", flag0, 1'b0);
    chk("R7", flag1, 1'b0);

    // R9 / R10: change lands on the capture phase
    cyc(6'h17, 6'h03, '1, 4'b0010, 1'b0, "R9 R10");
    chk("R9", flag0, 1'b0);
    chk("R10", flag1, 1'b1);
    cyc(6'h03, 6'h03, '1, 4'b0000, 1'b0, "R9");
    chk("R9", flag0, 1'b0);
    settle(6'h03, '1);
    // race plus clear: fixed variant still sets (R8)
    cyc(6'h03, 6'h30, '1, 4'b0010, 1'b1, "R8 R10");
    chk("R10", flag1, 1'b1);
    chk("R9", flag0, 1'b0);

    // exhaustive: every mask against every single-pin toggle
    for (int m = 0; m < 64; m++) begin
      for (int k = 0; k < W; k++) begin
        settle(6'h00, 6'(m));
        cyc(6'(1 << k), 6'(1 << k), 6'(m), 4'b0000, 1'b0, "R2 R3");
        chk("R3", flag0, m[k]);
      end
    end

    // pseudo-random mix of accesses, clears and pin motion
    for (int n = 0; n < 2000; n++) begin
      logic [W-1:0] a, b, e;
      logic [3:0] ap;
      a  = 6'($urandom);
      b  = ($urandom % 2) ? a : 6'($urandom);
      e  = 6'($urandom);
      ap = ($urandom % 3 == 0) ? 4'b0010 : 4'(1 << ($urandom % 4));
      cyc(a, b, e, ap, 1'($urandom % 2), "R6 R8 R9 R10");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule